// File: doc/BRIEF.md
# Instruction Cache Invalidation Walker

This block empties a read-only instruction cache when a single invalidate command arrives. The requester offers the command on a valid/ready handshake, together with a small tag that identifies it. Once the block accepts the command, it steps through every line index of the tag array, from the lowest to the highest. For each index it places one eviction request toward the tag controller. The controller acknowledges each eviction with a one-cycle done pulse.

A pending counter goes up by one for each eviction issued and down by one for each acknowledgement. The block returns exactly one completion pulse, carrying the captured tag, once the walk has finished and the counter has drained to zero. Only one command is held at a time. A done pulse that does not match an outstanding eviction is flagged as an error and has no other effect.

The per-line tag state is kept here only as a valid bit for each line. A fill strobe sets that bit, and an accepted eviction clears it whatever its previous value.

Top module: `icinv_walker`

## Requirements
- R1: After reset, `inv_req_ready` is 1, and `ev_valid`, `inv_rsp_valid`, `ack_err` and every bit of `line_valid` are 0.
- R2: A command is accepted in a cycle where `inv_req_valid` and `inv_req_ready` are both 1. From the next cycle, `inv_req_ready` stays 0 until the cycle in which the completion pulse is visible.
- R3: After acceptance, evictions are handed over (`ev_valid` and `ev_ready` both 1) in strictly ascending index order, starting at 0 and ending at NUM_LINES-1. Each index is handed over exactly once, and at most one per cycle. `ev_valid` is 0 whenever no command is held.
- R4: While `ev_valid` is 1 and `ev_ready` is 0, `ev_valid` stays 1 and `ev_index` holds its value in the next cycle.
- R5: An eviction handshake on index i makes `line_valid[i]` 0 in the next cycle, whether the line was valid or not. If `fill_en` is 1 and no eviction hits that index in the same cycle, `line_valid[fill_index]` is 1 in the next cycle. After a completion, every line is invalid.
- R6: `inv_rsp_valid` is a single-cycle pulse. It appears in the cycle after the one in which all NUM_LINES evictions have been handed over and as many valid done pulses have been received. `inv_rsp_tag` equals the tag captured at acceptance.
- R7: Done pulses may arrive in any cycle after their eviction was handed over, including the cycle of a later handshake. No completion appears while any eviction is unacknowledged.
- R8: A done pulse that arrives while no command is held, or while the pending count is zero, raises `ack_err` for one cycle in the next cycle. It does not change the pending count.
- R9: A second command offered while one is held is not accepted: `inv_req_ready` stays 0, and the completion returns the first command's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_req_valid | input | 1 | Invalidate command offered |
| inv_req_ready | output | 1 | Block can take a command (no command held) |
| inv_req_tag | input | TAG_W | Requester tag of the offered command |
| inv_rsp_valid | output | 1 | One-cycle completion pulse |
| inv_rsp_tag | output | TAG_W | Tag of the completed command |
| ev_valid | output | 1 | Eviction request present |
| ev_ready | input | 1 | Tag controller takes the eviction |
| ev_index | output | $clog2(NUM_LINES) | Line index of the eviction |
| ev_done | input | 1 | One eviction acknowledged |
| ack_err | output | 1 | One-cycle flag for an unmatched acknowledgement |
| fill_en | input | 1 | Mark a line valid |
| fill_index | input | $clog2(NUM_LINES) | Line index to mark valid |
| line_valid | output | NUM_LINES | Per-line valid bits |

## Verification
On every cycle, the assertions check the following local rules:
- the ready drop after acceptance;
- eviction hold under back-pressure;
- the one-step index advance;
- the clear of a handed-over line;
- the single-cycle completion carrying the captured tag;
- the error flag for a done pulse while idle.

Properties that span a whole command can only be shown by the bench scenarios, which model the outstanding evictions independently. These are the exact cycle of completion under random back-pressure and random acknowledgement latency, and the claim that every index is visited once. They also cover the fact that a rejected early acknowledgement leaves the count intact, so that completion still needs all NUM_LINES done pulses.

// File: rtl/icinv_pkg.sv
package icinv_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WALK  = 2'd1,
      PH_DRAIN = 2'd2
   } phase_e;
endpackage

// File: rtl/icinv_walk_seq.sv
module icinv_walk_seq
   import icinv_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int IDX_W     = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ev_ready,
   input  logic             drained,
   output phase_e           phase,
   output logic             ev_valid,
   output logic [IDX_W-1:0] ev_index,
   output logic             issue,
   output logic             finish
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

   phase_e           phase_q, phase_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             last_issue;

   always_comb begin
      issue      = (phase_q == PH_WALK) && ev_ready;
      last_issue = issue && (idx_q == LAST_IDX);
      finish     = (phase_q == PH_DRAIN) && drained;
      phase_d    = phase_q;
      idx_d      = idx_q;
      case (phase_q)
         PH_IDLE: begin
            if (start) begin
               phase_d = PH_WALK;
               idx_d   = '0;
            end
         end
         PH_WALK: begin
            if (last_issue) begin
               phase_d = PH_DRAIN;
            end else if (issue) begin
               idx_d = idx_q + IDX_W'(1);
            end
         end
         PH_DRAIN: begin
            if (drained) phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
      end else begin
         phase_q <= phase_d;
         idx_q   <= idx_d;
      end
   end

   assign phase    = phase_q;
   assign ev_valid = (phase_q == PH_WALK);
   assign ev_index = idx_q;
endmodule

// File: rtl/icinv_pend_ctr.sv
module icinv_pend_ctr #(
   parameter int NUM_LINES = 16,
   parameter int CNT_W     = $clog2(NUM_LINES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic ack,
   input  logic active,
   output logic spurious,
   output logic drained
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             ack_ok;

   always_comb begin
      ack_ok   = ack && active && (cnt_q != '0);
      spurious = ack && !ack_ok;
      cnt_d    = cnt_q + CNT_W'(inc) - CNT_W'(ack_ok);
      drained  = (cnt_d == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/icinv_line_state.sv
module icinv_line_state #(
   parameter int NUM_LINES = 16,
   parameter int IDX_W     = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_en,
   input  logic [IDX_W-1:0]     clr_idx,
   input  logic                 set_en,
   input  logic [IDX_W-1:0]     set_idx,
   output logic [NUM_LINES-1:0] valid
);
   for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
      logic hit_clr, hit_set;
      assign hit_clr = clr_en && (clr_idx == IDX_W'(gi));
      assign hit_set = set_en && (set_idx == IDX_W'(gi));
      always_ff @(posedge clk) begin
         if (!rst_n)       valid[gi] <= 1'b0;
         else if (hit_clr) valid[gi] <= 1'b0;
         else if (hit_set) valid[gi] <= 1'b1;
      end
   end
endmodule

// File: rtl/icinv_walker.sv
module icinv_walker
   import icinv_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int TAG_W     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         inv_req_valid,
   output logic                         inv_req_ready,
   input  logic [TAG_W-1:0]             inv_req_tag,
   output logic                         inv_rsp_valid,
   output logic [TAG_W-1:0]             inv_rsp_tag,
   output logic                         ev_valid,
   input  logic                         ev_ready,
   output logic [$clog2(NUM_LINES)-1:0] ev_index,
   input  logic                         ev_done,
   output logic                         ack_err,
   input  logic                         fill_en,
   input  logic [$clog2(NUM_LINES)-1:0] fill_index,
   output logic [NUM_LINES-1:0]         line_valid
);
   localparam int IDX_W = $clog2(NUM_LINES);
   localparam int CNT_W = $clog2(NUM_LINES + 1);

   if (NUM_LINES < 2) begin : g_bad_lines
      $error("icinv_walker: NUM_LINES must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("icinv_walker: TAG_W must be at least 1");
   end

   phase_e           phase;
   logic             busy, start, issue, finish, drained, spurious;
   logic [TAG_W-1:0] held_tag_q;
   logic             rsp_q, err_q;
   logic [TAG_W-1:0] rsp_tag_q;

   assign busy  = (phase != PH_IDLE);
   assign start = inv_req_valid && !busy;

   icinv_walk_seq #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ev_ready (ev_ready),
      .drained  (drained),
      .phase    (phase),
      .ev_valid (ev_valid),
      .ev_index (ev_index),
      .issue    (issue),
      .finish   (finish)
   );

   icinv_pend_ctr #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (issue),
      .ack      (ev_done),
      .active   (busy),
      .spurious (spurious),
      .drained  (drained)
   );

   icinv_line_state #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_en  (issue),
      .clr_idx (ev_index),
      .set_en  (fill_en),
      .set_idx (fill_index),
      .valid   (line_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_tag_q <= '0;
         rsp_q      <= 1'b0;
         rsp_tag_q  <= '0;
         err_q      <= 1'b0;
      end else begin
         if (start)  held_tag_q <= inv_req_tag;
         if (finish) rsp_tag_q  <= held_tag_q;
         rsp_q <= finish;
         err_q <= spurious;
      end
   end

   assign inv_req_ready = !busy;
   assign inv_rsp_valid = rsp_q;
   assign inv_rsp_tag   = rsp_tag_q;
   assign ack_err       = err_q;
endmodule

// File: rtl/icinv_walker_chk.sv
module icinv_walker_chk #(
   parameter int NUM_LINES = 16,
   parameter int TAG_W     = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         inv_req_valid,
   input logic                         inv_req_ready,
   input logic [TAG_W-1:0]             inv_req_tag,
   input logic                         inv_rsp_valid,
   input logic [TAG_W-1:0]             inv_rsp_tag,
   input logic                         ev_valid,
   input logic                         ev_ready,
   input logic [$clog2(NUM_LINES)-1:0] ev_index,
   input logic                         ev_done,
   input logic                         ack_err,
   input logic [NUM_LINES-1:0]         line_valid
);
   localparam int IDX_W = $clog2(NUM_LINES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

   logic [TAG_W-1:0] seen_tag_q;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_tag_q <= '0;
      else if (inv_req_valid && inv_req_ready) seen_tag_q <= inv_req_tag;
   end

   a_r1_idle_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
      inv_req_ready |-> !ev_valid);

   a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_req_valid && inv_req_ready) |=> !inv_req_ready);

   a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_ready && ev_index != LAST_IDX)
      |=> (ev_valid && ev_index == $past(ev_index) + IDX_W'(1)));

   a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_index)));

   a_r5_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_ready) |=> !line_valid[$past(ev_index)]);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      inv_rsp_valid |=> !inv_rsp_valid);

   a_r6_rsp_tag: assert property (@(posedge clk) disable iff (!rst_n)
      inv_rsp_valid |-> (inv_rsp_tag == seen_tag_q));

   a_r8_idle_ack_err: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done && inv_req_ready) |=> ack_err);
endmodule

bind icinv_walker icinv_walker_chk #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .inv_req_valid (inv_req_valid),
   .inv_req_ready (inv_req_ready),
   .inv_req_tag   (inv_req_tag),
   .inv_rsp_valid (inv_rsp_valid),
   .inv_rsp_tag   (inv_rsp_tag),
   .ev_valid      (ev_valid),
   .ev_ready      (ev_ready),
   .ev_index      (ev_index),
   .ev_done       (ev_done),
   .ack_err       (ack_err),
   .line_valid    (line_valid)
);

// File: tb/sim_icinv_walker.sv
module sim_icinv_walker;
   localparam int N  = 16;
   localparam int IW = $clog2(N);
   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          inv_req_valid = 1'b0;
   logic          inv_req_ready;
   logic [TW-1:0] inv_req_tag = '0;
   logic          inv_rsp_valid;
   logic [TW-1:0] inv_rsp_tag;
   logic          ev_valid;
   logic          ev_ready = 1'b0;
   logic [IW-1:0] ev_index;
   logic          ev_done = 1'b0;
   logic          ack_err;
   logic          fill_en = 1'b0;
   logic [IW-1:0] fill_index = '0;
   logic [N-1:0]  line_valid;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] model_valid = '0;

   always #10 clk = ~clk;

   icinv_walker #(.NUM_LINES(N), .TAG_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .inv_req_valid(inv_req_valid), .inv_req_ready(inv_req_ready),
      .inv_req_tag(inv_req_tag),
      .inv_rsp_valid(inv_rsp_valid), .inv_rsp_tag(inv_rsp_tag),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_index(ev_index),
      .ev_done(ev_done), .ack_err(ack_err),
      .fill_en(fill_en), .fill_index(fill_index), .line_valid(line_valid)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit want_ack(input int outstanding, input int pct);
      return (outstanding > 0) && ($urandom_range(99) < pct);
   endfunction

   // R5: mark one line valid through the fill strobe
   task automatic fill_line(input int idx);
      @(negedge clk);
      fill_en    = 1'b1;
      fill_index = IW'(idx);
      @(negedge clk);
      fill_en = 1'b0;
      model_valid[idx] = 1'b1;
      chk(line_valid === model_valid, "R5", "fill sets line", line_valid, model_valid);
   endtask

   task automatic run_inv(input logic [TW-1:0] tag, input int rdy_pct,
                          input int ack_pct, input bit early_bad_ack,
                          input bit poke_busy);
      int  nexp = 0;
      int  outst = 0;
      int  issued = 0;
      int  cyc = 0;
      bit  exp_rsp = 0;
      bit  exp_err = 0;
      bit  prev_stall = 0;
      logic [IW-1:0] prev_idx = '0;
      @(negedge clk);
      inv_req_valid = 1'b1;
      inv_req_tag   = tag;
      #1;
      chk(inv_req_ready === 1'b1, "R2", "ready when idle", inv_req_ready, 1);
      @(negedge clk);
      inv_req_valid = 1'b0;
      chk(inv_req_ready === 1'b0, "R2", "ready drops after accept", inv_req_ready, 0);
      forever begin
         ev_ready = ($urandom_range(99) < rdy_pct);
         ev_done  = want_ack(outst, ack_pct);
         exp_err  = 1'b0;
         if (early_bad_ack && cyc == 0) begin
            ev_ready = 1'b0;
            ev_done  = 1'b1;
            exp_err  = 1'b1;
         end
         if (poke_busy && cyc >= 2 && cyc <= 4) begin
            inv_req_valid = 1'b1;
            inv_req_tag   = tag ^ {TW{1'b1}};
         end else begin
            inv_req_valid = 1'b0;
         end
         #1;
         if (poke_busy && cyc >= 2 && cyc <= 4)
            chk(inv_req_ready === 1'b0, "R9", "busy refuses command", inv_req_ready, 0);
         if (prev_stall)
            chk(ev_valid === 1'b1 && ev_index === prev_idx, "R4", "held under stall",
                ev_index, prev_idx);
         if (issued == N)
            chk(ev_valid === 1'b0, "R3", "no eviction after walk", ev_valid, 0);
         prev_stall = ev_valid && !ev_ready;
         prev_idx   = ev_index;
         if (ev_done && outst > 0) outst--;
         if (ev_valid && ev_ready) begin
            chk(ev_index === IW'(nexp), "R3", "eviction order", ev_index, nexp);
            model_valid[ev_index] = 1'b0;
            nexp++;
            issued++;
            outst++;
         end
         exp_rsp = (issued == N) && (outst == 0);
         @(negedge clk);
         ev_done = 1'b0;
         chk(inv_rsp_valid === exp_rsp, "R7", "completion timing", inv_rsp_valid, exp_rsp);
         chk(ack_err === exp_err, "R8", "error flag", ack_err, exp_err);
         cyc++;
         if (exp_rsp) begin
            chk(inv_rsp_tag === tag, "R6", "completion tag", inv_rsp_tag, tag);
            chk(inv_req_ready === 1'b1, "R2", "ready back at completion", inv_req_ready, 1);
            break;
         end
         if (cyc > 4000) begin
            chk(1'b0, "R6", "completion never came", 0, 1);
            break;
         end
      end
      ev_ready = 1'b0;
      inv_req_valid = 1'b0;
      chk(line_valid === '0, "R5", "all lines invalid after completion", line_valid, 0);
      @(negedge clk);
      chk(inv_rsp_valid === 1'b0, "R6", "pulse is one cycle", inv_rsp_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h1c4a7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(inv_req_ready === 1'b1, "R1", "ready", inv_req_ready, 1);
      chk(ev_valid === 1'b0, "R1", "ev_valid", ev_valid, 0);
      chk(inv_rsp_valid === 1'b0, "R1", "rsp", inv_rsp_valid, 0);
      chk(ack_err === 1'b0, "R1", "err", ack_err, 0);
      chk(line_valid === '0, "R1", "lines", line_valid, 0);

      // R8: acknowledgement while idle
      @(negedge clk);
      ev_done = 1'b1;
      @(negedge clk);
      ev_done = 1'b0;
      chk(ack_err === 1'b1, "R8", "idle ack flagged", ack_err, 1);
      chk(inv_rsp_valid === 1'b0, "R8", "idle ack no completion", inv_rsp_valid, 0);
      @(negedge clk);
      chk(ack_err === 1'b0, "R8", "flag one cycle", ack_err, 0);

      // directed: all lines valid, no back-pressure, immediate acks
      for (int i = 0; i < N; i++) fill_line(i);
      run_inv(4'h5, 100, 100, 1'b0, 1'b0);

      // directed: first and last line valid, heavy stall, busy poke
      fill_line(0);
      fill_line(N - 1);
      run_inv(4'hA, 30, 40, 1'b0, 1'b1);

      // directed: ack with zero pending while busy, slow acks
      fill_line(7);
      run_inv(4'h3, 80, 10, 1'b1, 1'b0);

      // random runs
      for (int r = 0; r < 6; r++) begin
         int nf = $urandom_range(N);
         for (int k = 0; k < nf; k++) fill_line($urandom_range(N - 1));
         run_inv(TW'($urandom), $urandom_range(20, 100), $urandom_range(5, 100),
                 1'(r % 2), 1'(r % 3 == 0));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule